// File: doc/BRIEF.md
# Shared-Bus Multicycle Processor Datapath

This block is a small processor core in which every data transfer passes over one 16-bit bus. A one-hot multiplexer chooses the bus source from eight general registers, the external data input and a result register. A 2-bit step counter and a decoder run each instruction over one or three clock cycles. An instruction can copy one register to another, load an immediate value taken from the data input, or add or subtract two registers. For an add or subtract, the first operand is staged in an operand register. The sum or difference is caught in a result register and copied back on a third bus cycle.

Instructions are applied on a 9-bit input. They advance only while the run input is high. The opcode and register fields are captured in the first step, so the instruction input is free to change once that step has been taken. The done output marks the final step of each instruction. The current bus value is brought out so that register contents and intermediate results can be observed.

Top module: `busproc_core`

## Requirements
- R1: Synchronous reset clears all eight general registers, the operand register, the result register and the step counter. After reset, with run low, bus_out is 0 and done is 0.
- R2: Instruction layout: bits [8:6] hold the opcode, bits [5:3] the destination field X and bits [2:0] the source field Y. The opcodes are move=000, immediate=001, add=010 and subtract=011.
- R3: Move takes one cycle. In step 0, bus_out shows RY and done is high. RX takes the value of RY at the next clock edge.
- R4: Immediate takes one cycle. In step 0, bus_out shows din and done is high. RX takes the value of din at the next clock edge.
- R5: Add takes three steps, and bus_out shows a different value in each. Step 0 shows RX, and RX is loaded into the operand register. Step 1 shows RY, and the sum is loaded into the result register. Step 2 shows the result, and the result is written to RX. Done is high only in step 2. The sum wraps modulo 2^16.
- R6: Subtract follows the same three steps as add and writes RX minus RY modulo 2^16.
- R7: While run is low, the step counter holds and no register loads. Bus_out is 0 and done is 0.
- R8: The opcode and the X and Y fields are captured in step 0. Changes to the instruction input during steps 1 and 2 have no effect.
- R9: Opcodes 100 to 111 finish in step 0 with done high and bus_out 0, and they change no register.
- R10: At most one bus source is selected in any cycle, and exactly one is selected whenever any register load is enabled.
- R11: A reset applied in the middle of an instruction abandons that instruction. The next instruction starts in step 0.
- R12: The step after a done step is step 0, so instructions can be issued back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Step enable; the instruction advances only while high |
| instr | input | 9 | Instruction: opcode, X field, Y field |
| din | input | 16 | Immediate data source for the bus |
| done | output | 1 | High in the final step of an instruction |
| bus_out | output | 16 | Current bus value |

## Verification
Some properties are checked by assertions in every cycle. The bus select must have at most one bit set, and exactly one whenever a load is enabled. The step counter must hold while run is low and return to 0 after done. Step 3 must never be reached. With run low, the bus must be idle and done low. The arithmetic values, wrap-around, immediate loads, the capture of the instruction fields and the effect of the undefined opcodes can only be shown by the bench's scenarios. The bench reads registers back over the bus with self-moves and compares them against its own register model.

// File: rtl/busproc_pkg.sv
package busproc_pkg;
   localparam int OPC_W  = 3;
   localparam int STEP_W = 2;

   localparam logic [OPC_W-1:0] OPC_MOVE = 3'b000;
   localparam logic [OPC_W-1:0] OPC_IMM  = 3'b001;
   localparam logic [OPC_W-1:0] OPC_ADD  = 3'b010;
   localparam logic [OPC_W-1:0] OPC_SUB  = 3'b011;

   localparam logic [STEP_W-1:0] STEP_FIRST  = 2'd0;
   localparam logic [STEP_W-1:0] STEP_SECOND = 2'd1;
   localparam logic [STEP_W-1:0] STEP_LAST   = 2'd2;
endpackage

// File: rtl/busproc_ctrl.sv
module busproc_ctrl
   import busproc_pkg::*;
#(
   parameter int RIDX_W = 3
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       run,
   input  logic [OPC_W+2*RIDX_W-1:0]  instr,
   output logic                       done,
   output logic [(1<<RIDX_W)+1:0]     sel,
   output logic [(1<<RIDX_W)-1:0]     ld_r,
   output logic                       ld_a,
   output logic                       ld_g,
   output logic                       sub_op
);
   localparam int NREG    = 1 << RIDX_W;
   localparam int SRC_DIN = NREG;
   localparam int SRC_RES = NREG + 1;
   localparam int INSTR_W = OPC_W + 2*RIDX_W;

   logic [STEP_W-1:0]  step_q;
   logic [INSTR_W-1:0] ir_q;
   logic [OPC_W-1:0]   op;
   logic [RIDX_W-1:0]  fx, fy;

   // step 0 decodes the live input, later steps the captured copy
   always_comb begin
      if (step_q == STEP_FIRST) {op, fx, fy} = instr;
      else                      {op, fx, fy} = ir_q;
   end

   always_comb begin
      sel    = '0;
      ld_r   = '0;
      ld_a   = 1'b0;
      ld_g   = 1'b0;
      sub_op = 1'b0;
      done   = 1'b0;
      if (run) begin
         case (step_q)
            STEP_FIRST: begin
               case (op)
                  OPC_MOVE: begin sel[fy] = 1'b1;      ld_r[fx] = 1'b1; done = 1'b1; end
                  OPC_IMM:  begin sel[SRC_DIN] = 1'b1; ld_r[fx] = 1'b1; done = 1'b1; end
                  OPC_ADD, OPC_SUB: begin sel[fx] = 1'b1; ld_a = 1'b1; end
                  default:  done = 1'b1;
               endcase
            end
            STEP_SECOND: begin
               sel[fy] = 1'b1;
               ld_g    = 1'b1;
               sub_op  = (op == OPC_SUB);
            end
            STEP_LAST: begin
               sel[SRC_RES] = 1'b1;
               ld_r[fx]     = 1'b1;
               done         = 1'b1;
            end
            default: done = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst)       step_q <= STEP_FIRST;
      else if (run)  step_q <= done ? STEP_FIRST : step_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)                               ir_q <= '0;
      else if (run && step_q == STEP_FIRST)  ir_q <= instr;
   end

   AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
      !run |=> $stable(step_q)); // R7
   AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
      (run && done) |=> step_q == STEP_FIRST); // R12
   AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
      step_q != 2'd3); // R5
   AST_LOAD_SOURCE: assert property (@(posedge clk) disable iff (rst)
      ((|ld_r) || ld_a || ld_g) |-> $countones(sel) == 1); // R10
endmodule

// File: rtl/busproc_regfile.sv
module busproc_regfile #(
   parameter int DATA_W = 16,
   parameter int NREG   = 8
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [NREG-1:0]               ld,
   input  logic [DATA_W-1:0]             d,
   output logic [NREG-1:0][DATA_W-1:0]   q
);
   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [DATA_W-1:0] r_q;
      always_ff @(posedge clk) begin
         if (rst)        r_q <= '0;
         else if (ld[i]) r_q <= d;
      end
      assign q[i] = r_q;
   end

   AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
      $onehot0(ld)); // R3
endmodule

// File: rtl/busproc_bus_mux.sv
module busproc_bus_mux #(
   parameter int DATA_W = 16,
   parameter int NSRC   = 10
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [NSRC-1:0]              sel,
   input  logic [NSRC-1:0][DATA_W-1:0]  src,
   output logic [DATA_W-1:0]            bus
);
   always_comb begin
      bus = '0;
      for (int i = 0; i < NSRC; i++)
         bus = bus | (src[i] & {DATA_W{sel[i]}});
   end

   AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sel)); // R10
endmodule

// File: rtl/busproc_alu.sv
module busproc_alu #(
   parameter int DATA_W       = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              sub_op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   if (SHARED_ADDER) begin : g_shared
      assign y = a + (b ^ {DATA_W{sub_op}}) + {{(DATA_W-1){1'b0}}, sub_op};
   end else begin : g_split
      assign y = sub_op ? (a - b) : (a + b);
   end
endmodule

// File: rtl/busproc_core.sv
module busproc_core
   import busproc_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int RIDX_W       = 3,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       run,
   input  logic [OPC_W+2*RIDX_W-1:0]  instr,
   input  logic [DATA_W-1:0]          din,
   output logic                       done,
   output logic [DATA_W-1:0]          bus_out
);
   localparam int NREG = 1 << RIDX_W;
   localparam int NSRC = NREG + 2;

   if (DATA_W < 2) begin : g_bad_width
      $error("busproc_core: DATA_W must be at least 2");
   end
   if (RIDX_W < 1 || RIDX_W > 4) begin : g_bad_ridx
      $error("busproc_core: RIDX_W must lie in 1..4");
   end

   logic [NSRC-1:0]             sel;
   logic [NREG-1:0]             ld_r;
   logic                        ld_a, ld_g, sub_op;
   logic [NREG-1:0][DATA_W-1:0] regs;
   logic [NSRC-1:0][DATA_W-1:0] src;
   logic [DATA_W-1:0]           bus, a_q, g_q, alu_y;

   busproc_ctrl #(.RIDX_W(RIDX_W)) u_ctrl (
      .clk(clk), .rst(rst), .run(run), .instr(instr), .done(done),
      .sel(sel), .ld_r(ld_r), .ld_a(ld_a), .ld_g(ld_g), .sub_op(sub_op)
   );

   busproc_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
      .clk(clk), .rst(rst), .ld(ld_r), .d(bus), .q(regs)
   );

   assign src = {g_q, din, regs};

   busproc_bus_mux #(.DATA_W(DATA_W), .NSRC(NSRC)) u_mux (
      .clk(clk), .rst(rst), .sel(sel), .src(src), .bus(bus)
   );

   busproc_alu #(.DATA_W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .sub_op(sub_op), .a(a_q), .b(bus), .y(alu_y)
   );

   always_ff @(posedge clk) begin
      if (rst)       a_q <= '0;
      else if (ld_a) a_q <= bus;
   end

   always_ff @(posedge clk) begin
      if (rst)       g_q <= '0;
      else if (ld_g) g_q <= alu_y;
   end

   assign bus_out = bus;

   AST_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
      !run |-> bus_out == '0); // R7
   AST_IDLE_DONE: assert property (@(posedge clk) disable iff (rst)
      !run |-> !done); // R7
endmodule

// File: tb/busproc_core_bench.sv
module busproc_core_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        run = 1'b0;
   logic [8:0]  instr = '0;
   logic [15:0] din = '0;
   logic        done;
   logic [15:0] bus_out;

   always #5 clk = ~clk;

   busproc_core u_busproc_core (
      .clk(clk), .rst(rst), .run(run), .instr(instr), .din(din),
      .done(done), .bus_out(bus_out)
   );

   typedef struct {
      logic [15:0] bus;
      logic        dn;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          vectors = 0;
   int          fails = 0;
   bit          finished = 0;
   logic [15:0] m [8];

   // monitor: compares the expected item pushed in this cycle
   initial begin
      forever begin
         @(negedge clk);
         #3;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            vectors++;
            if (bus_out !== e.bus || done !== e.dn) begin
               fails++;
               $display("FAIL %s: bus=%h done=%b expected bus=%h done=%b",
                        e.tag, bus_out, done, e.bus, e.dn);
            end
         end
      end
   end

   task automatic cyc(input logic r, input logic [8:0] ins, input logic [15:0] d,
                      input logic [15:0] eb, input logic ed, input string tg);
      exp_t e;
      @(negedge clk);
      run = r; instr = ins; din = d;
      e.bus = eb; e.dn = ed; e.tag = tg;
      sb.push_back(e);
   endtask

   task automatic do_mv(input logic [2:0] x, input logic [2:0] y, input string tg);
      cyc(1'b1, {3'b000, x, y}, 16'hDEAD, m[y], 1'b1, tg);
      m[x] = m[y];
   endtask

   task automatic do_mvi(input logic [2:0] x, input logic [15:0] v, input string tg);
      cyc(1'b1, {3'b001, x, 3'd5}, v, v, 1'b1, tg);
      m[x] = v;
   endtask

   task automatic read_reg(input logic [2:0] k, input string tg);
      cyc(1'b1, {3'b000, k, k}, 16'h0BAD, m[k], 1'b1, tg);
   endtask

   task automatic do_arith(input logic is_sub, input logic [2:0] x, input logic [2:0] y,
                           input bit stall, input bit scramble, input string tg);
      logic [15:0] res;
      logic [8:0]  ins, later;
      res   = is_sub ? (m[x] - m[y]) : (m[x] + m[y]);
      ins   = {(is_sub ? 3'b011 : 3'b010), x, y};
      later = scramble ? ~ins : ins;
      cyc(1'b1, ins, 16'h0F0F, m[x], 1'b0, tg);
      if (stall) begin
         cyc(1'b0, later, 16'h5555, 16'h0000, 1'b0, "R7");
         cyc(1'b0, later, 16'h5555, 16'h0000, 1'b0, "R7");
      end
      cyc(1'b1, later, 16'h0F0F, m[y], 1'b0, tg);
      cyc(1'b1, later, 16'h0F0F, res, 1'b1, tg);
      m[x] = res;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: run did not end, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 8; k++) m[k] = 16'h0000;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: idle after reset, all registers zero
      cyc(1'b0, 9'h000, 16'hFFFF, 16'h0000, 1'b0, "R1");
      for (int k = 0; k < 8; k++) read_reg(3'(k), "R1");

      // R4 / R2: immediates into every register
      for (int k = 0; k < 8; k++) do_mvi(3'(k), 16'h1111 * 16'(k + 1), "R4");
      for (int k = 0; k < 8; k++) read_reg(3'(k), "R2");

      // R10: bus carries only din while every register is non-zero
      do_mvi(3'd0, 16'hA5C3, "R10");

      // R3: moves
      do_mv(3'd5, 3'd2, "R3");
      read_reg(3'd5, "R3");
      read_reg(3'd2, "R3");

      // R5: add, normal and wrap
      do_arith(1'b0, 3'd1, 3'd2, 1'b0, 1'b0, "R5");
      read_reg(3'd1, "R5");
      do_mvi(3'd6, 16'hFFFF, "R4");
      do_mvi(3'd7, 16'h0002, "R4");
      do_arith(1'b0, 3'd6, 3'd7, 1'b0, 1'b0, "R5");
      read_reg(3'd6, "R5");

      // R6: subtract with borrow, and self-subtract
      do_mvi(3'd3, 16'h0005, "R4");
      do_mvi(3'd4, 16'h0007, "R4");
      do_arith(1'b1, 3'd3, 3'd4, 1'b0, 1'b0, "R6");
      read_reg(3'd3, "R6");
      do_arith(1'b1, 3'd4, 3'd4, 1'b0, 1'b0, "R6");
      read_reg(3'd4, "R6");

      // R7: stall mid-add
      do_arith(1'b0, 3'd0, 3'd1, 1'b1, 1'b0, "R7");
      read_reg(3'd0, "R7");
      read_reg(3'd1, "R7");

      // R8: instruction input changes after step 0
      do_arith(1'b1, 3'd2, 3'd5, 1'b0, 1'b1, "R8");
      for (int k = 0; k < 8; k++) read_reg(3'(k), "R8");

      // R12: back-to-back after a three-step instruction
      do_arith(1'b0, 3'd7, 3'd7, 1'b0, 1'b0, "R12");
      do_mvi(3'd6, 16'h7E57, "R12");
      read_reg(3'd7, "R12");

      // R9: undefined opcodes
      cyc(1'b1, {3'b100, 3'd1, 3'd2}, 16'h1234, 16'h0000, 1'b1, "R9");
      cyc(1'b1, {3'b111, 3'd3, 3'd3}, 16'h4321, 16'h0000, 1'b1, "R9");
      cyc(1'b1, {3'b110, 3'd0, 3'd6}, 16'h9999, 16'h0000, 1'b1, "R9");
      for (int k = 0; k < 8; k++) read_reg(3'(k), "R9");

      // R11: reset in the middle of an add
      cyc(1'b1, {3'b010, 3'd1, 3'd2}, 16'h0000, m[1], 1'b0, "R11");
      cyc(1'b1, {3'b010, 3'd1, 3'd2}, 16'h0000, m[2], 1'b0, "R11");
      @(negedge clk);
      rst = 1'b1; run = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < 8; k++) m[k] = 16'h0000;
      cyc(1'b1, {3'b001, 3'd4, 3'd0}, 16'h4242, 16'h4242, 1'b1, "R11");
      m[4] = 16'h4242;
      read_reg(3'd4, "R11");
      read_reg(3'd1, "R11");
      do_arith(1'b0, 3'd4, 3'd4, 1'b0, 1'b0, "R11");
      read_reg(3'd4, "R11");

      cyc(1'b0, 9'h000, 16'h0000, 16'h0000, 1'b0, "R7");
      @(negedge clk);
      #5;
      finished = 1;
      summary();
      $finish;
   end
endmodule